// File: doc/BRIEF.md
# Condition Code Flag Unit

This block derives the four arithmetic status flags (negative, zero, two's-complement overflow and carry/borrow) for one operation and folds them into an 8-bit condition code byte. The caller supplies the operation class, a byte or word size select, both operands, the result that its own datapath already produced, the carry that a shift moved out, and the current condition byte. The unit computes no sum or difference itself. It only judges the operands and result it is given.

The updated condition byte is registered and appears one clock after a valid request. Only the flags that the operation class defines are rewritten. The four upper control bits, and the carry during a test, come through unchanged. In byte mode the upper half of every operand and of the result is ignored.

Top module: `ccu_flag_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and `ccr_out` is 8'h00.
- R2: A request with `in_valid` high produces `out_valid` high on the following cycle. When `in_valid` is low, `out_valid` is low on the next cycle and `ccr_out` keeps its value.
- R3: Condition byte layout, bit 7 down to bit 0: four pass-through control bits [7:4], then N (bit 3), Z (bit 2), V (bit 1), C (bit 0). `op` encoding: 2'b00 add, 2'b01 subtract, 2'b10 test, 2'b11 shift. `wide`=1 selects 16-bit, `wide`=0 selects 8-bit.
- R4: For add, C is set when at least two of {a msb, b msb, NOT r msb} are 1. V is set when the a and b sign bits are equal and the r sign bit differs from them.
- R5: For subtract, C (borrow) is set when at least two of {NOT a msb, b msb, r msb} are 1. V is set when the a and b sign bits differ and the r sign bit differs from a's.
- R6: N copies the result's sign bit (bit 7 in byte mode, bit 15 in word mode). Z is 1 exactly when the selected width of the result is all zero. In byte mode, bits [15:8] of `opa`, `opb` and `res` have no effect.
- R7: For test, V becomes 0 and C keeps its incoming value.
- R8: For shift, C takes `shift_c`, and V equals the new N XOR the new C.
- R9: Bits [7:4] of `ccr_out` equal bits [7:4] of the `ccr_in` presented with the request, for every operation class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation class (R3 encoding) |
| wide | input | 1 | 1: word operands, 0: byte operands |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| res | input | 16 | Result produced by the datapath |
| shift_c | input | 1 | Bit shifted out, used for the shift class |
| ccr_in | input | 8 | Current condition byte |
| out_valid | output | 1 | Updated byte is valid |
| ccr_out | output | 8 | Updated condition byte |

## Verification
The case that is hardest to reach is byte mode with non-zero upper halves. A datapath that behaves correctly would never present those bits, yet a wrong width select only shows up through them. The stimulus therefore deliberately pairs byte-mode requests with upper bytes that would flip N, Z, C or V if they were used, for example a word result of 16'hAB00 that must read as zero. The stimulus also drives results that are inconsistent with the operands, so that the carry and overflow equations are tested on their own and not only on true sums. Tests and shifts are issued with the incoming carry both set and clear, which separates a preserved carry from a recomputed one.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_TST = 2'b10,
    OP_SHF = 2'b11
  } ccu_op_e;

  localparam int CCR_W = 8;
  localparam int BIT_C = 0;
  localparam int BIT_V = 1;
  localparam int BIT_Z = 2;
  localparam int BIT_N = 3;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccu_flags_t;

endpackage

// File: rtl/ccu_flag_calc.sv
module ccu_flag_calc
  import ccu_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  ccu_op_e          op,
  input  logic             wide,
  input  logic [WIDE_W-1:0] opa,
  input  logic [WIDE_W-1:0] opb,
  input  logic [WIDE_W-1:0] res,
  input  logic             shift_c,
  input  logic             c_in,
  output ccu_flags_t       flags_o
);

  localparam int N_LANES = 2;

  ccu_flags_t lane_f [N_LANES];

  // lane 0 judges the narrow size, lane 1 the wide size
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
    logic [LW-1:0] a, b, r;
    logic [LW-1:0] add_cy, add_ov, sub_cy, sub_ov;
    ccu_flags_t    lf;

    assign a = opa[LW-1:0];
    assign b = opb[LW-1:0];
    assign r = res[LW-1:0];

    assign add_cy = (a & b) | (b & ~r) | (a & ~r);
    assign add_ov = (a & b & ~r) | (~a & ~b & r);
    assign sub_cy = (~a & b) | (b & r) | (~a & r);
    assign sub_ov = (a & ~b & ~r) | (~a & b & r);

    always_comb begin
      lf.n = r[LW-1];
      lf.z = (r == '0);
      unique case (op)
        OP_ADD: begin
          lf.c = add_cy[LW-1];
          lf.v = add_ov[LW-1];
        end
        OP_SUB: begin
          lf.c = sub_cy[LW-1];
          lf.v = sub_ov[LW-1];
        end
        OP_TST: begin
          lf.c = c_in;
          lf.v = 1'b0;
        end
        default: begin
          lf.c = shift_c;
          lf.v = r[LW-1] ^ shift_c;
        end
      endcase
    end

    assign lane_f[g] = lf;
  end

  assign flags_o = wide ? lane_f[1] : lane_f[0];

endmodule

// File: rtl/ccu_ccr_merge.sv
module ccu_ccr_merge
  import ccu_pkg::*;
(
  input  ccu_op_e          op,
  input  logic [CCR_W-1:0] ccr_in,
  input  ccu_flags_t       flags,
  output logic [CCR_W-1:0] ccr_o
);

  logic [CCR_W-1:0] mask;
  logic [CCR_W-1:0] fvec;

  always_comb begin
    fvec        = '0;
    fvec[BIT_N] = flags.n;
    fvec[BIT_Z] = flags.z;
    fvec[BIT_V] = flags.v;
    fvec[BIT_C] = flags.c;

    mask        = '0;
    mask[BIT_N] = 1'b1;
    mask[BIT_Z] = 1'b1;
    mask[BIT_V] = 1'b1;
    mask[BIT_C] = (op != OP_TST);

    ccr_o = (ccr_in & ~mask) | (fvec & mask);
  end

endmodule

// File: rtl/ccu_flag_unit.sv
module ccu_flag_unit
  import ccu_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              wide,
  input  logic [WIDE_W-1:0] opa,
  input  logic [WIDE_W-1:0] opb,
  input  logic [WIDE_W-1:0] res,
  input  logic              shift_c,
  input  logic [7:0]        ccr_in,
  output logic              out_valid,
  output logic [7:0]        ccr_out
);

  ccu_op_e          op_e;
  ccu_flags_t       flags;
  logic [CCR_W-1:0] ccr_next;

  assign op_e = ccu_op_e'(op);

  ccu_flag_calc #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W)
  ) u_calc (
    .op      (op_e),
    .wide    (wide),
    .opa     (opa),
    .opb     (opb),
    .res     (res),
    .shift_c (shift_c),
    .c_in    (ccr_in[BIT_C]),
    .flags_o (flags)
  );

  ccu_ccr_merge u_merge (
    .op     (op_e),
    .ccr_in (ccr_in),
    .flags  (flags),
    .ccr_o  (ccr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ccr_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) ccr_out <= ccr_next;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(ccr_out))); // R2
  AST_UPPER_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ccr_out[7:4] == $past(ccr_in[7:4])); // R9
  AST_TEST_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10) |=>
      (!ccr_out[BIT_V] && ccr_out[BIT_C] == $past(ccr_in[BIT_C]))); // R7
  AST_SHIFT_C: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> ccr_out[BIT_C] == $past(shift_c)); // R8
  AST_SHIFT_V: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=>
      ccr_out[BIT_V] == (ccr_out[BIT_N] ^ ccr_out[BIT_C])); // R8
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide && res[NARROW_W-1:0] == '0) |=>
      (ccr_out[BIT_Z] && !ccr_out[BIT_N])); // R6

endmodule

// File: tb/tb_ccu_flag_unit.sv
module tb_ccu_flag_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op;
  logic        wide;
  logic [15:0] opa, opb, res;
  logic        shift_c;
  logic [7:0]  ccr_in;
  logic        out_valid;
  logic [7:0]  ccr_out;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  logic [7:0]  last_exp = 8'h00;
  bit          started  = 1'b0;
  bit          done     = 1'b0;

  always #2 clk = ~clk;

  ccu_flag_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide),
    .opa(opa), .opb(opb), .res(res), .shift_c(shift_c), .ccr_in(ccr_in),
    .out_valid(out_valid), .ccr_out(ccr_out)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
    end
  endtask

  // reference: majority of three bits
  function automatic bit maj(input bit x, input bit y, input bit z);
    return (x && y) || (x && z) || (y && z);
  endfunction

  task automatic send(input logic [1:0] o, input bit w, input logic [15:0] a,
                      input logic [15:0] b, input logic [15:0] r, input bit sc,
                      input logic [7:0] cc, input string tag);
    int  m;
    bit  sa, sb, sr, n, z, c, v;
    logic [7:0] e;
    m  = w ? 15 : 7;
    sa = a[m]; sb = b[m]; sr = r[m];
    n  = sr;
    z  = w ? (r == 16'h0) : (r[7:0] == 8'h0);
    c  = cc[0];
    v  = 1'b0;
    case (o)
      2'b00: begin c = maj(sa, sb, !sr); v = (sa == sb) && (sr != sa); end
      2'b01: begin c = maj(!sa, sb, sr); v = (sa != sb) && (sr != sa); end
      2'b10: begin v = 1'b0; end
      default: begin c = sc; v = n ^ sc; end
    endcase
    e = {cc[7:4], n, z, v, c};
    @(negedge clk);
    in_valid = 1'b1; op = o; wide = w; opa = a; opb = b; res = r;
    shift_c = sc; ccr_in = cc;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = 16'hFFFF; opb = 16'hFFFF; res = 16'h1234; ccr_in = 8'hA5;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (started && !rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", ccr_out, 8'h00);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          check(ccr_out === e, t, ccr_out, e);
        end
      end else begin
        check(ccr_out === last_exp, "R2 hold while idle", ccr_out, last_exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=%02h expected=%02h", ccr_out, 8'h00);
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; op = 2'b00; wide = 1'b0;
    opa = 16'hFFFF; opb = 16'hFFFF; res = 16'h0000; shift_c = 1'b1; ccr_in = 8'hFF;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && ccr_out === 8'h00, "R1 in reset",
          {7'b0, out_valid} | ccr_out, 8'h00);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && ccr_out === 8'h00, "R1 after reset",
          {7'b0, out_valid} | ccr_out, 8'h00);
    started = 1'b1;

    // R4 byte add
    send(2'b00, 0, 16'h007F, 16'h0001, 16'h0080, 0, 8'h00, "R4 add 7F+01");
    send(2'b00, 0, 16'h00FF, 16'h0001, 16'h0000, 0, 8'h00, "R4 add FF+01");
    send(2'b00, 0, 16'h0080, 16'h0080, 16'h0000, 0, 8'h00, "R4 add 80+80");
    // R5 byte subtract
    send(2'b01, 0, 16'h0000, 16'h0001, 16'h00FF, 0, 8'h00, "R5 sub 00-01");
    send(2'b01, 0, 16'h0080, 16'h0001, 16'h007F, 0, 8'h00, "R5 sub 80-01");
    send(2'b01, 0, 16'h0005, 16'h0005, 16'h0000, 0, 8'h0F, "R5 sub equal");
    // R3 word mode
    send(2'b00, 1, 16'h7FFF, 16'h0001, 16'h8000, 0, 8'h00, "R3 R4 word add");
    send(2'b01, 1, 16'h8000, 16'h0001, 16'h7FFF, 0, 8'h00, "R3 R5 word sub");
    // R6 byte mode ignores upper halves
    send(2'b00, 0, 16'hFF00, 16'hFF00, 16'hAB00, 0, 8'h00, "R6 narrow upper ignored");
    send(2'b01, 0, 16'h7F12, 16'h8034, 16'h80DE, 0, 8'h00, "R6 narrow sub upper");
    send(2'b10, 1, 16'h0, 16'h0, 16'h8000, 0, 8'h00, "R6 word sign");
    send(2'b10, 1, 16'h0, 16'h0, 16'h0000, 0, 8'h00, "R6 word zero");
    // R7 test keeps carry
    send(2'b10, 0, 16'h0, 16'h0, 16'h0042, 1, 8'h03, "R7 test C=1 kept");
    send(2'b10, 0, 16'h0, 16'h0, 16'h0080, 1, 8'h02, "R7 test C=0 kept");
    // R8 shift
    send(2'b11, 0, 16'h0, 16'h0, 16'h0080, 0, 8'h01, "R8 shift N=1 C=0");
    send(2'b11, 0, 16'h0, 16'h0, 16'h0000, 1, 8'h00, "R8 shift Z C=1");
    send(2'b11, 1, 16'h0, 16'h0, 16'h8001, 1, 8'h00, "R8 shift word N=C");
    // R9 control bits pass through
    send(2'b00, 0, 16'h0001, 16'h0001, 16'h0002, 0, 8'hF0, "R9 upper F0");
    send(2'b11, 0, 16'h0, 16'h0, 16'h0001, 1, 8'hA0, "R9 upper A0");
    idle(4);
    send(2'b01, 0, 16'h0010, 16'h0020, 16'h00F0, 0, 8'h50, "R2 after idle");
    idle(3);

    for (int i = 0; i < 300; i++) begin
      logic [15:0] a, b, r;
      logic [1:0]  o;
      a = 16'($urandom); b = 16'($urandom);
      o = 2'($urandom);
      case (o)
        2'b00: r = a + b;
        2'b01: r = a - b;
        default: r = 16'($urandom);
      endcase
      if (($urandom % 4) == 0) r = 16'($urandom);
      send(o, 1'($urandom), a, b, r, 1'($urandom), 8'($urandom), "R3 random mix");
      if (($urandom % 5) == 0) idle(1);
    end
    idle(4);
    check(exp_q.size() == 0, "R2 all results delivered", 8'(exp_q.size()), 8'h00);
    finish_run();
  end

endmodule